// File: doc/BRIEF.md
# Context-Banked Register File

This block holds the general-purpose registers of a processor as several banks, one bank per hardware context. A 4-bit context number, kept in the status state of the block, selects the active bank: every physical register address is the context number placed above the 5-bit architectural register number. Both read ports and the write-back port use this address, so a change of context swaps the whole register set at once.

On exception entry, and only when the switching enable bit is set, the block moves to another bank without any register being saved to memory. An elaboration parameter chooses how it moves: either it advances the context number by one, or it sends it back to the main context, number zero. The number in use before the exception is copied to a saved-context output, for the exception status register, and to a previous-context output, so that a handler can find the interrupted register set. On exception return the context number is loaded from the exception status input. Software can also write the enable bit and the context number directly.

Top module: `ctx_regfile`

## Requirements
- R1: After reset the context number is 0, the switching enable is 0, the saved-context and previous-context outputs are 0 and the wrap flag is low.
- R2: The physical register used by each read port and by the write-back port is the current context number concatenated above the 5-bit register number, so each of the 16 banks keeps its own 31 writable registers, readable on both read ports.
- R3: A software status write (sr_wr_en high) loads sr_wr_ce into the enable bit and sr_wr_cid into the context number; both are visible on the outputs in the cycle after the write.
- R4: An exception entry with the enable bit clear leaves the context number unchanged.
- R5: With ZERO_ON_ENTRY = 0 and the enable bit set, an exception entry makes the next context number the current one plus one.
- R6: With ZERO_ON_ENTRY = 1 and the enable bit set, an exception entry makes the next context number 0.
- R7: Every exception entry copies the context number in use before it to esr_cid_out and to prev_ctx_id, visible in the next cycle.
- R8: An exception return loads esr_cid_in into the context number, visible in the next cycle, so the first access after the return uses the restored bank.
- R9: In advance mode, entry from context 15 gives context 0, and ctx_wrap is high for exactly the one cycle after that entry and low otherwise.
- R10: Register number 0 reads as zero on both read ports in every bank, and write-backs to it have no effect.
- R11: A write-back in the same cycle as a context change is stored in the bank that was active before the change.
- R12: When several context updates arrive in one cycle, exception entry wins over exception return, and exception return wins over a software status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wb_en | input | 1 | Write-back enable |
| wb_addr | input | 5 | Write-back register number |
| wb_data | input | DATA_W | Write-back data |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| sr_wr_en | input | 1 | Software status write strobe |
| sr_wr_ce | input | 1 | Enable bit value to write |
| sr_wr_cid | input | 4 | Context number value to write |
| esr_cid_in | input | 4 | Saved context number restored on return |
| esr_cid_out | output | 4 | Context number saved at the last entry |
| prev_ctx_id | output | 4 | Context number active before the last entry |
| ctx_en | output | 1 | Current switching enable bit |
| ctx_id | output | 4 | Current context number |
| ctx_wrap | output | 1 | One-cycle pulse when advance wraps 15 to 0 |

## Verification
The assertions take for granted that the strobe inputs are never unknown after reset and that exception entry and return are not raised together except in deliberate priority tests, whose outcome R12 defines. The stimulus changes every input on the falling clock edge, holds each strobe for a single cycle, and fills every register of every bank before reading any of them, so no read sees uninitialised storage. Both entry modes are covered by two instances fed from the same stimulus, and the bench predicts each context number arithmetically from the previous one.

// File: rtl/ctx_rf_pkg.sv
package ctx_rf_pkg;

    localparam int CTX_W   = 4;
    localparam int ARCH_AW = 5;
    localparam int N_CTX   = 1 << CTX_W;
    localparam int N_REG   = 1 << ARCH_AW;

    typedef logic [CTX_W-1:0]   ctx_t;
    typedef logic [ARCH_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic en;
        ctx_t cid;
        ctx_t esr;
        ctx_t prev;
        logic wrap;
    } ctx_state_t;

endpackage

// File: rtl/ctx_id_ctrl.sv
module ctx_id_ctrl
    import ctx_rf_pkg::*;
#(
    parameter bit ZERO_ON_ENTRY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_enter,
    input  logic exc_return,
    input  logic sr_wr_en,
    input  logic sr_wr_ce,
    input  ctx_t sr_wr_cid,
    input  ctx_t esr_cid_in,
    output logic ctx_en,
    output ctx_t ctx_id,
    output ctx_t esr_cid_out,
    output ctx_t prev_ctx_id,
    output logic ctx_wrap
);

    localparam ctx_t CID_TOP = ctx_t'(N_CTX - 1);

    ctx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (exc_enter) begin
            st_d.esr  = st_q.cid;
            st_d.prev = st_q.cid;
            if (st_q.en) begin
                if (ZERO_ON_ENTRY) begin
                    st_d.cid = '0;
                end else begin
                    st_d.cid  = st_q.cid + ctx_t'(1);
                    st_d.wrap = (st_q.cid == CID_TOP);
                end
            end
        end else if (exc_return) begin
            st_d.cid = esr_cid_in;
        end else if (sr_wr_en) begin
            st_d.en  = sr_wr_ce;
            st_d.cid = sr_wr_cid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctx_en      = st_q.en;
    assign ctx_id      = st_q.cid;
    assign esr_cid_out = st_q.esr;
    assign prev_ctx_id = st_q.prev;
    assign ctx_wrap    = st_q.wrap;

    // R4: disabled switching keeps the bank on entry
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && !ctx_en) |=> (ctx_id == $past(ctx_id)));

    // R5: advance mode steps by one
    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!ZERO_ON_ENTRY && exc_enter && ctx_en) |=> (ctx_id == $past(ctx_id) + ctx_t'(1)));

    // R6: zero mode returns to the main context
    a_r6_to_main: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_ON_ENTRY && exc_enter && ctx_en) |=> (ctx_id == '0));

    // R7: interrupted context saved on both outputs
    a_r7_saved: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (esr_cid_out == $past(ctx_id) && prev_ctx_id == $past(ctx_id)));

    // R8: return restores from the exception status input
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> (ctx_id == $past(esr_cid_in)));

    // R9: wrap pulse only after an entry and never two cycles running
    a_r9_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_wrap |-> ($past(exc_enter) && ctx_id == '0));
    a_r9_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_wrap |=> !ctx_wrap);

endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import ctx_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  reg_idx_t          waddr,
    input  logic [DATA_W-1:0] wdata,
    input  reg_idx_t          raddr_a,
    input  reg_idx_t          raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs_q [N_REG];

    // R10: register 0 is never stored
    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs_q[waddr] <= wdata;
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
    import ctx_rf_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter bit ZERO_ON_ENTRY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [4:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wb_en,
    input  logic [4:0]        wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              sr_wr_en,
    input  logic              sr_wr_ce,
    input  logic [3:0]        sr_wr_cid,
    input  logic [3:0]        esr_cid_in,
    output logic [3:0]        esr_cid_out,
    output logic [3:0]        prev_ctx_id,
    output logic              ctx_en,
    output logic [3:0]        ctx_id,
    output logic              ctx_wrap
);

    ctx_t              cur_cid;
    logic [DATA_W-1:0] bank_rd_a [N_CTX];
    logic [DATA_W-1:0] bank_rd_b [N_CTX];

    ctx_id_ctrl #(.ZERO_ON_ENTRY(ZERO_ON_ENTRY)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_enter   (exc_enter),
        .exc_return  (exc_return),
        .sr_wr_en    (sr_wr_en),
        .sr_wr_ce    (sr_wr_ce),
        .sr_wr_cid   (sr_wr_cid),
        .esr_cid_in  (esr_cid_in),
        .ctx_en      (ctx_en),
        .ctx_id      (cur_cid),
        .esr_cid_out (esr_cid_out),
        .prev_ctx_id (prev_ctx_id),
        .ctx_wrap    (ctx_wrap)
    );

    // R2, R11: bank chosen by the registered context number, so a write in
    // the cycle of a context change lands in the bank active before it
    for (genvar b = 0; b < N_CTX; b++) begin : g_bank
        rf_bank #(.DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .we      (wb_en && cur_cid == ctx_t'(b)),
            .waddr   (wb_addr),
            .wdata   (wb_data),
            .raddr_a (rd_a_addr),
            .raddr_b (rd_b_addr),
            .rdata_a (bank_rd_a[b]),
            .rdata_b (bank_rd_b[b])
        );
    end

    assign rd_a_data = bank_rd_a[cur_cid];
    assign rd_b_data = bank_rd_b[cur_cid];
    assign ctx_id    = cur_cid;

    // R10: register 0 reads zero on both ports
    a_r10_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));
    a_r10_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

endmodule

// File: tb/sim_ctx_regfile.sv
module sim_ctx_regfile;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic        wb_en = 1'b0, exc_enter = 1'b0, exc_return = 1'b0;
    logic        sr_wr_en = 1'b0, sr_wr_ce = 1'b0;
    logic [3:0]  sr_wr_cid = '0, esr_in = '0;

    logic [31:0] rda, rdb, z_rda, z_rdb;
    logic [3:0]  esr_out, prev, cid, z_esr, z_prev, z_cid;
    logic        en, wrap, z_en, z_wrap;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    ctx_regfile #(.DATA_W(32), .ZERO_ON_ENTRY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rda),
        .rd_b_addr(rd_b_addr), .rd_b_data(rdb),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .exc_enter(exc_enter), .exc_return(exc_return),
        .sr_wr_en(sr_wr_en), .sr_wr_ce(sr_wr_ce), .sr_wr_cid(sr_wr_cid),
        .esr_cid_in(esr_in), .esr_cid_out(esr_out), .prev_ctx_id(prev),
        .ctx_en(en), .ctx_id(cid), .ctx_wrap(wrap)
    );

    ctx_regfile #(.DATA_W(32), .ZERO_ON_ENTRY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(z_rda),
        .rd_b_addr(rd_b_addr), .rd_b_data(z_rdb),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .exc_enter(exc_enter), .exc_return(exc_return),
        .sr_wr_en(sr_wr_en), .sr_wr_ce(sr_wr_ce), .sr_wr_cid(sr_wr_cid),
        .esr_cid_in(esr_in), .esr_cid_out(z_esr), .prev_ctx_id(z_prev),
        .ctx_en(z_en), .ctx_id(z_cid), .ctx_wrap(z_wrap)
    );

    function automatic logic [31:0] pat(int b, int r);
        return (32'h5A00_0000 + r) ^ (32'(b) * 32'h0101_0101) ^ (32'(r) << 16);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change on the falling edge; outputs are read one falling edge later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic sr_write(logic ce, logic [3:0] c);
        sr_wr_en = 1'b1; sr_wr_ce = ce; sr_wr_cid = c;
        step();
        sr_wr_en = 1'b0;
    endtask

    task automatic wb(logic [4:0] a, logic [31:0] d);
        wb_en = 1'b1; wb_addr = a; wb_data = d;
        step();
        wb_en = 1'b0;
    endtask

    task automatic enter();
        exc_enter = 1'b1;
        step();
        exc_enter = 1'b0;
    endtask

    initial begin
        #(PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 cid", 32'(cid), 0);
        chk("R1 en", 32'(en), 0);
        chk("R1 esr", 32'(esr_out), 0);
        chk("R1 prev", 32'(prev), 0);
        chk("R1 wrap", 32'(wrap), 0);

        // R2: fill every register of every bank, register 0 included (R10)
        for (int b = 0; b < 16; b++) begin
            sr_write(1'b0, 4'(b));
            chk("R3 cid", 32'(cid), 32'(b));
            for (int r = 0; r < 32; r++) wb(5'(r), pat(b, r));
        end
        for (int b = 0; b < 16; b++) begin
            sr_write(1'b0, 4'(b));
            for (int r = 0; r < 32; r++) begin
                rd_a_addr = 5'(r); rd_b_addr = 5'(31 - r);
                #1;
                chk("R2/R10 port A", rda, (r == 0) ? 32'h0 : pat(b, r));
                chk("R2/R10 port B", rdb, (r == 31) ? 32'h0 : pat(b, 31 - r));
            end
        end

        // R3: enable bit write
        sr_write(1'b1, 4'd6);
        chk("R3 en", 32'(en), 1);
        chk("R3 cid", 32'(cid), 6);

        // R4: entry with enable off keeps bank
        sr_write(1'b0, 4'd9);
        enter();
        chk("R4 cid", 32'(cid), 9);
        chk("R7 esr", 32'(esr_out), 9);

        // R5/R6/R7 across all start values
        for (int c = 0; c < 16; c++) begin
            sr_write(1'b1, 4'(c));
            enter();
            chk("R5 cid", 32'(cid), 32'((c + 1) % 16));
            chk("R6 cid", 32'(z_cid), 0);
            chk("R7 esr", 32'(esr_out), 32'(c));
            chk("R7 prev", 32'(prev), 32'(c));
            chk("R9 wrap", 32'(wrap), (c == 15) ? 1 : 0);
            chk("R9 wrap zero mode", 32'(z_wrap), 0);
            step();
            chk("R9 wrap clears", 32'(wrap), 0);
        end

        // R8: return restores from input, first read uses restored bank
        for (int c = 0; c < 16; c += 5) begin
            esr_in = 4'(c);
            exc_return = 1'b1;
            step();
            exc_return = 1'b0;
            chk("R8 cid", 32'(cid), 32'(c));
            rd_a_addr = 5'd12; #1;
            chk("R8 bank read", rda, pat(c, 12));
        end

        // R11: write-back during entry lands in old bank
        sr_write(1'b1, 4'd3);
        exc_enter = 1'b1; wb_en = 1'b1; wb_addr = 5'd7; wb_data = 32'hCAFE_0007;
        step();
        exc_enter = 1'b0; wb_en = 1'b0;
        chk("R11 cid moved", 32'(cid), 4);
        rd_a_addr = 5'd7; #1;
        chk("R11 new bank untouched", rda, pat(4, 7));
        sr_write(1'b1, 4'd3);
        rd_a_addr = 5'd7; #1;
        chk("R11 old bank written", rda, 32'hCAFE_0007);

        // R10: write to r0 has no effect
        wb(5'd0, 32'hFFFF_FFFF);
        rd_a_addr = 5'd0; rd_b_addr = 5'd0; #1;
        chk("R10 r0 A", rda, 0);
        chk("R10 r0 B", rdb, 0);

        // R12: priorities
        sr_write(1'b1, 4'd10);
        esr_in = 4'd2;
        exc_enter = 1'b1; exc_return = 1'b1;
        step();
        exc_enter = 1'b0; exc_return = 1'b0;
        chk("R12 entry over return", 32'(cid), 11);
        exc_return = 1'b1; sr_wr_en = 1'b1; sr_wr_ce = 1'b0; sr_wr_cid = 4'd13;
        step();
        exc_return = 1'b0; sr_wr_en = 1'b0;
        chk("R12 return over write cid", 32'(cid), 2);
        chk("R12 return over write en", 32'(en), 1);

        // R1 again after a mid-run reset
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R1 cid after reset", 32'(cid), 0);
        chk("R1 en after reset", 32'(en), 0);
        chk("R1 prev after reset", 32'(prev), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule